// File: doc/BRIEF.md
# Character LCD 4-Bit Write Sequencer

This block drives a parallel character display controller over a 4-bit data bus with a register-select line and an enable strobe. The read/write line is tied to write outside the block, and the block never reads the busy flag. All timing is counted in system clock cycles, and every limit is a parameter. After reset the block waits out a power-up delay. It then puts the controller into 4-bit mode by strobing four lone nibbles, 3, 3, 3 and 2, with a pause after each one.

Once initialisation is done, the block takes bytes over a valid/ready stream. Each byte carries a select bit that chooses between command (0) and character data (1). A byte is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` then drops in the next cycle and stays low until the byte has gone out as two nibbles, upper nibble first, and a fixed settle delay has passed. An upstream source that sees `in_ready` low must hold `in_valid` and its byte unchanged. Bytes offered while `in_ready` is low have no effect.

Every strobe follows a strict order. Data and select are placed on the bus, a setup interval passes, enable rises, enable stays high for a minimum width, enable falls, and a hold interval passes before the bus may change again.

Top module: `lcd_nibble_writer`

## Requirements
- R1: While reset is asserted, `lcd_en`, `lcd_rs`, `lcd_d` and `in_ready` are all 0.
- R2: Enable does not rise before `POWERUP_CYC` cycles have passed since reset was released.
- R3: The first four enable pulses carry select 0 and nibbles 4'h3, 4'h3, 4'h3, 4'h2, in that order. Before each of the second to fourth pulses, and before the first byte pulse, enable stays low for at least `INIT_GAP_CYC` cycles.
- R4: `in_ready` is high only when no transfer or delay is pending, and never while enable is high. A byte is taken on `in_valid && in_ready`. `in_ready` is 0 in the following cycle.
- R5: Each accepted byte produces exactly two enable pulses, bits [7:4] first and then bits [3:0], both with `lcd_rs` equal to the byte's select bit.
- R6: `lcd_d` and `lcd_rs` are unchanged for at least `SETUP_CYC` cycles before enable rises.
- R7: Enable stays high for at least `EN_HIGH_CYC` cycles, and `lcd_d` and `lcd_rs` do not change while it is high.
- R8: After enable falls, `lcd_d` and `lcd_rs` do not change for at least `HOLD_CYC` cycles.
- R9: After the lower nibble of a byte, enable stays low for at least `CMD_CYC` cycles. For a clear or home command (select 0, byte 8'h01, 8'h02 or 8'h03) it stays low for at least `LONG_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered on the input stream |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_byte | input | 8 | Command or character byte |
| in_sel | input | 1 | 0 = command, 1 = character data |
| lcd_rs | output | 1 | Register select to the display |
| lcd_en | output | 1 | Enable strobe to the display |
| lcd_d | output | 4 | Data nibble to the display |

## Verification
The bench sends every one of the 256 byte values as character data. Because both nibbles of every value are exercised, the bench can detect swapped or wrongly split nibbles and a wrong select level. It then sends commands 8'h00 to 8'h0F plus several higher command codes, so the clear and home codes 8'h01 to 8'h03 can be told apart from 8'h00 and 8'h04 by their settle delay. Idle gaps of varying length between bytes, and bytes offered while `in_ready` is low, test the back-pressure rule. Every enable pulse, setup interval and hold interval is measured against the configured minimums.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

  typedef enum logic [3:0] {
    S_PWR, S_INIT_GO, S_INIT_PULSE, S_INIT_GAP, S_IDLE,
    S_HI_GO, S_HI_PULSE, S_LO_GO, S_LO_PULSE, S_SETTLE
  } seq_state_t;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_HIGH, PH_HOLD} phase_t;

  localparam int INIT_STEPS = 4;

  // nibble sent at each initialisation step: three times 3, then 2
  function automatic logic [3:0] init_nibble(input logic [1:0] step);
    return (step == 2'd3) ? 4'h2 : 4'h3;
  endfunction

  // clear (01) and home (02/03) need the long settle delay
  function automatic logic is_slow_cmd(input logic sel, input logic [7:0] b);
    return !sel && (b[7:2] == 6'd0) && (b[1:0] != 2'd0);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcdw_delay.sv
module lcdw_delay #(
  parameter int W       = 8,
  parameter int RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/lcdw_strobe.sv
module lcdw_strobe
  import lcdw_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int EN_HIGH_CYC = 3,
  parameter int HOLD_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       nib_rs,
  input  logic [3:0] nib,
  output logic       done,
  output logic       lcd_rs,
  output logic       lcd_en,
  output logic [3:0] lcd_d
);
  localparam int MAXC = max2(max2(SETUP_CYC, EN_HIGH_CYC), HOLD_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] HIGH_LD  = CW'(EN_HIGH_CYC - 1);
  localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC - 1);

  phase_t        phase;
  logic [CW-1:0] cnt;

  // bus changes only when a new nibble starts; enable follows the phases
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      lcd_rs <= 1'b0;
      lcd_en <= 1'b0;
      lcd_d  <= 4'h0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          lcd_rs <= nib_rs;
          lcd_d  <= nib;
          cnt    <= SETUP_LD;
          phase  <= PH_SETUP;
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            lcd_en <= 1'b1;
            cnt    <= HIGH_LD;
            phase  <= PH_HIGH;
          end else cnt <= cnt - 1'b1;
        end
        PH_HIGH: begin
          if (cnt == '0) begin
            lcd_en <= 1'b0;
            cnt    <= HOLD_LD;
            phase  <= PH_HOLD;
          end else cnt <= cnt - 1'b1;
        end
        PH_HOLD: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign done = (phase == PH_HOLD) && (cnt == '0);
endmodule

// File: rtl/lcdw_seq.sv
module lcdw_seq
  import lcdw_pkg::*;
#(
  parameter int W            = 8,
  parameter int INIT_GAP_CYC = 12,
  parameter int CMD_CYC      = 6,
  parameter int LONG_CYC     = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [7:0]   in_byte,
  input  logic         in_sel,
  input  logic         tmr_expired,
  output logic         tmr_load,
  output logic [W-1:0] tmr_val,
  input  logic         strobe_done,
  output logic         strobe_start,
  output logic         strobe_rs,
  output logic [3:0]   strobe_nib
);
  localparam logic [W-1:0] GAP_LD  = W'(INIT_GAP_CYC);
  localparam logic [W-1:0] CMD_LD  = W'(CMD_CYC);
  localparam logic [W-1:0] LONG_LD = W'(LONG_CYC);

  seq_state_t state;
  logic [1:0] step;
  logic [7:0] byte_q;
  logic       sel_q;
  logic       slow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_PWR;
      step   <= 2'd0;
      byte_q <= 8'h00;
      sel_q  <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      case (state)
        S_PWR:        if (tmr_expired) state <= S_INIT_GO;
        S_INIT_GO:    state <= S_INIT_PULSE;
        S_INIT_PULSE: if (strobe_done) state <= S_INIT_GAP;
        S_INIT_GAP: if (tmr_expired) begin
          if (step == 2'(INIT_STEPS - 1)) state <= S_IDLE;
          else begin
            step  <= step + 1'b1;
            state <= S_INIT_GO;
          end
        end
        S_IDLE: if (in_valid) begin
          byte_q <= in_byte;
          sel_q  <= in_sel;
          slow_q <= is_slow_cmd(in_sel, in_byte);
          state  <= S_HI_GO;
        end
        S_HI_GO:    state <= S_HI_PULSE;
        S_HI_PULSE: if (strobe_done) state <= S_LO_GO;
        S_LO_GO:    state <= S_LO_PULSE;
        S_LO_PULSE: if (strobe_done) state <= S_SETTLE;
        S_SETTLE:   if (tmr_expired) state <= S_IDLE;
        default:    state <= S_PWR;
      endcase
    end
  end

  always_comb begin
    in_ready     = (state == S_IDLE);
    strobe_start = (state == S_INIT_GO) || (state == S_HI_GO) || (state == S_LO_GO);
    strobe_rs    = (state == S_HI_GO || state == S_LO_GO) ? sel_q : 1'b0;
    case (state)
      S_INIT_GO: strobe_nib = init_nibble(step);
      S_HI_GO:   strobe_nib = byte_q[7:4];
      default:   strobe_nib = byte_q[3:0];
    endcase
    tmr_load = 1'b0;
    tmr_val  = GAP_LD;
    if (state == S_INIT_PULSE && strobe_done) begin
      tmr_load = 1'b1;
      tmr_val  = GAP_LD;
    end else if (state == S_LO_PULSE && strobe_done) begin
      tmr_load = 1'b1;
      tmr_val  = slow_q ? LONG_LD : CMD_LD;
    end
  end
endmodule

// File: rtl/lcd_nibble_writer.sv
module lcd_nibble_writer
  import lcdw_pkg::*;
#(
  parameter int SETUP_CYC    = 3,
  parameter int EN_HIGH_CYC  = 25,
  parameter int HOLD_CYC     = 2,
  parameter int POWERUP_CYC  = 2000000,
  parameter int INIT_GAP_CYC = 250000,
  parameter int CMD_CYC      = 2500,
  parameter int LONG_CYC     = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic       in_sel,
  output logic       lcd_rs,
  output logic       lcd_en,
  output logic [3:0] lcd_d
);
  localparam int MAXD = max2(max2(POWERUP_CYC, INIT_GAP_CYC), max2(CMD_CYC, LONG_CYC));
  localparam int W    = $clog2(MAXD + 1);

  logic         tmr_load, tmr_expired;
  logic [W-1:0] tmr_val;
  logic         s_start, s_done, s_rs;
  logic [3:0]   s_nib;

  lcdw_delay #(.W(W), .RST_VAL(POWERUP_CYC)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  lcdw_seq #(
    .W(W), .INIT_GAP_CYC(INIT_GAP_CYC), .CMD_CYC(CMD_CYC), .LONG_CYC(LONG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_sel(in_sel), .tmr_expired(tmr_expired),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .strobe_done(s_done),
    .strobe_start(s_start), .strobe_rs(s_rs), .strobe_nib(s_nib)
  );

  lcdw_strobe #(
    .SETUP_CYC(SETUP_CYC), .EN_HIGH_CYC(EN_HIGH_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .start(s_start), .nib_rs(s_rs), .nib(s_nib),
    .done(s_done), .lcd_rs(lcd_rs), .lcd_en(lcd_en), .lcd_d(lcd_d)
  );
endmodule

// File: rtl/lcdw_checker.sv
module lcdw_checker #(
  parameter int EN_HIGH_CYC = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       lcd_rs,
  input logic       lcd_en,
  input logic [3:0] lcd_d
);
  localparam int HW = $clog2(EN_HIGH_CYC + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_cnt <= '0;
    else if (!lcd_en) hi_cnt <= '0;
    else if (hi_cnt != {HW{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_BUS_STILL_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en) |-> ($stable(lcd_d) && $stable(lcd_rs))); // R6
  AST_BUS_STILL_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && $past(lcd_en)) |-> ($stable(lcd_d) && $stable(lcd_rs))); // R7
  AST_EN_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_en) |-> (32'(hi_cnt) >= EN_HIGH_CYC)); // R7
  AST_BUS_STILL_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_en) |-> ($stable(lcd_d) && $stable(lcd_rs))); // R8
  AST_NO_READY_WHILE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |-> !in_ready); // R4
  AST_READY_DROPS_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R4
endmodule

bind lcd_nibble_writer lcdw_checker #(.EN_HIGH_CYC(EN_HIGH_CYC)) u_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .lcd_rs(lcd_rs), .lcd_en(lcd_en), .lcd_d(lcd_d)
);

// File: tb/tb_lcd_nibble_writer.sv
`timescale 1ns/1ps
module tb_lcd_nibble_writer;
  localparam int SETUP_CYC = 2, EN_HIGH_CYC = 3, HOLD_CYC = 2;
  localparam int POWERUP_CYC = 40, INIT_GAP_CYC = 12, CMD_CYC = 6, LONG_CYC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_sel = 1'b0;
  logic in_ready, lcd_rs, lcd_en;
  logic [3:0] lcd_d;

  always #5 clk = ~clk;

  lcd_nibble_writer #(
    .SETUP_CYC(SETUP_CYC), .EN_HIGH_CYC(EN_HIGH_CYC), .HOLD_CYC(HOLD_CYC),
    .POWERUP_CYC(POWERUP_CYC), .INIT_GAP_CYC(INIT_GAP_CYC),
    .CMD_CYC(CMD_CYC), .LONG_CYC(LONG_CYC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_sel(in_sel), .lcd_rs(lcd_rs), .lcd_en(lcd_en),
    .lcd_d(lcd_d)
  );

  int checks = 0, errors = 0;
  logic [3:0] exp_nib [0:1023];
  logic       exp_rs  [0:1023];
  int         exp_gap [0:1023];
  int wr_idx = 0, rd_idx = 0;
  int pending_gap = INIT_GAP_CYC;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic rs, input logic [3:0] n, input int gap);
    exp_rs[wr_idx] = rs; exp_nib[wr_idx] = n; exp_gap[wr_idx] = gap;
    wr_idx++;
  endtask

  // monitor: samples away from the active edge
  int cyc = 0, last_change = 0, last_fall = 0, rise_at = 0;
  bit seen_fall = 1'b0;
  logic prev_en = 1'b0, prev_rs = 1'b0;
  logic [3:0] prev_d = 4'h0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (lcd_d !== prev_d || lcd_rs !== prev_rs) begin
        if (lcd_en && prev_en) check(1'b0, "R7", "bus moved while enable high", 1, 0);
        if (seen_fall) check(cyc - last_fall >= HOLD_CYC, "R8", "hold cycles",
                             cyc - last_fall, HOLD_CYC);
        last_change = cyc;
      end
      if (lcd_en && !prev_en) begin
        rise_at = cyc;
        check(cyc - last_change >= SETUP_CYC, "R6", "setup cycles",
              cyc - last_change, SETUP_CYC);
        check(!in_ready, "R4", "ready during enable", int'(in_ready), 0);
        if (rd_idx < wr_idx) begin
          string req;
          req = (rd_idx < 4) ? "R3" : "R5";
          check(lcd_d == exp_nib[rd_idx], req, "nibble", int'(lcd_d), int'(exp_nib[rd_idx]));
          check(lcd_rs == exp_rs[rd_idx], req, "select", int'(lcd_rs), int'(exp_rs[rd_idx]));
          if (rd_idx == 0)
            check(cyc >= POWERUP_CYC, "R2", "first rise cycle", cyc, POWERUP_CYC);
          else if (rd_idx <= 4)
            check(cyc - last_fall >= exp_gap[rd_idx], "R3", "init gap",
                  cyc - last_fall, exp_gap[rd_idx]);
          else
            check(cyc - last_fall >= exp_gap[rd_idx], "R9", "settle gap",
                  cyc - last_fall, exp_gap[rd_idx]);
        end else check(1'b0, "R5", "unexpected enable pulse", rd_idx, wr_idx);
        rd_idx++;
      end
      if (!lcd_en && prev_en) begin
        check(cyc - rise_at >= EN_HIGH_CYC, "R7", "enable width",
              cyc - rise_at, EN_HIGH_CYC);
        last_fall = cyc;
        seen_fall = 1'b1;
      end
      prev_en = lcd_en; prev_rs = lcd_rs; prev_d = lcd_d;
    end
  end

  task automatic send(input logic sel, input logic [7:0] b);
    bit slow;
    slow = !sel && (b[7:2] == 6'd0) && (b[1:0] != 2'd0);
    push(sel, b[7:4], pending_gap);
    push(sel, b[3:0], 0);
    pending_gap = slow ? LONG_CYC : CMD_CYC;
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_sel = sel;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_byte = ~b;
    check(!in_ready, "R4", "ready after accept", int'(in_ready), 0);
  endtask

  bit finished = 1'b0;

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    check(1'b0, "R4", "watchdog expired", rd_idx, wr_idx);
    finish_run();
  end

  initial begin
    push(1'b0, 4'h3, POWERUP_CYC);
    push(1'b0, 4'h3, INIT_GAP_CYC);
    push(1'b0, 4'h3, INIT_GAP_CYC);
    push(1'b0, 4'h2, INIT_GAP_CYC);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!lcd_en && !lcd_rs && lcd_d == 4'h0 && !in_ready, "R1", "reset outputs",
            int'({lcd_en, lcd_rs, lcd_d, in_ready}), 0);
    end
    rst_n = 1'b1;
    // character sweep: every byte value, with varying idle gaps
    for (int b = 0; b < 256; b++) begin
      for (int k = 0; k < (b % 4); k++) @(negedge clk);
      send(1'b1, 8'(b));
    end
    // command sweep including the clear and home codes
    for (int b = 0; b < 16; b++) send(1'b0, 8'(b));
    send(1'b0, 8'h28);
    send(1'b0, 8'h80);
    send(1'b0, 8'hC0);
    for (int k = 0; k < LONG_CYC + 20; k++) @(negedge clk);
    check(rd_idx == wr_idx, "R5", "pulse count", rd_idx, wr_idx);
    check(in_ready, "R4", "ready after final settle", int'(in_ready), 1);
    finish_run();
  end
endmodule